// File: doc/BRIEF.md
# Snoop Filter Directory for a Private L1

This block sits between a shared system bus and a processor that has a private L1 cache. It decides, for each snoop seen on the bus, whether the operation must be passed up to the processor or can finish on the bus without it. Filtering these snoops keeps traffic that cannot matter away from the processor.

To make that decision it keeps two structures. The first is a direct-mapped shadow of the L1 tags, with a coarse state for each line. The second is a small set of copy-back address registers. These hold lines that the L1 has displaced and not yet written back.

The L1 side reports allocations and displacements. An allocation writes a shadow entry. The entry is marked EX when the line is not shared and S when it is, because a silent exclusive-to-modified change inside the processor cannot be seen from outside. The valid bit of the entry is written with the bus global flag of that transfer. A displacement moves the line address of the set, and its valid bit, into the next copy-back register in round-robin order, and clears the shadow entry.

The snoop side presents a line address, an operation type and a global flag. The lookup is combinational. Its result passes through a three-state output machine, and the answer appears as a one-cycle strobe in the cycle after the request. The machine states are:
- IDLE: no answer this cycle.
- FWD: pass the snoop to the processor.
- CMPL: complete the snoop without the processor.

The transitions are:
- From any state to FWD on a snoop that must be forwarded.
- From any state to CMPL on a snoop that can complete.
- From any state to IDLE when there is no snoop.

Top module: `snoop_filter_dir`

## Requirements
- R1: After reset, `resp_valid` is low, and every shadow entry and every copy-back register is invalid, so a global memory snoop to any line completes (`resp_fwd`=0).
- R2: Each cycle with `snp_valid` high produces exactly one cycle of `resp_valid` in the next cycle. Back-to-back requests give back-to-back answers, and no answer appears without a request.
- R3: An operation type with bit 2 set is non-memory (100 TLB invalidate, 101 sync, 110/111 other). Such a snoop is always forwarded, whatever the global flag and the address.
- R4: A memory snoop is any type with bit 2 clear: 000 read, 001 read-for-ownership, 010 write-with-kill, 011 kill. A memory snoop with `snp_global`=0 completes, even when its line is present.
- R5: A global memory snoop is forwarded when its line equals the line of a shadow entry whose valid bit is 1 and whose state is S or EX. A line is the set index in the low 6 bits plus the tag above them.
- R6: An allocation writes the entry's valid bit with `alloc_global`. A line allocated with `alloc_global`=0 does not cause a forward.
- R7: `alloc_shared`=1 records state S and `alloc_shared`=0 records state EX. Both states count as present for filtering.
- R8: A displacement of set `evict_set` copies that set's line and valid bit into a copy-back register and clears the shadow entry. A global memory snoop to a copied line whose valid bit was 1 is forwarded. A copied line whose valid bit was 0 does not forward.
- R9: Displacements fill the 2 copy-back registers in turn, starting at register 0. The third displacement overwrites the line saved by the first.
- R10: A global write-with-kill (type 010) that matches a copy-back register is forwarded and clears that register's valid bit. A later global snoop to the same line then completes.
- R11: A global memory snoop whose set matches a valid entry but whose tag differs completes.
- R12: When an allocation and a displacement name the same set in one cycle, the copy-back register receives the old line and the shadow entry holds the new one. Both lines are then forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | L1 allocates a line this cycle |
| alloc_line | input | 27 | Line address of the allocation (tag and set) |
| alloc_shared | input | 1 | Allocated line is shared (state S), else EX |
| alloc_global | input | 1 | Bus global flag of the allocating transfer |
| evict_valid | input | 1 | L1 displaces the line held in a set |
| evict_set | input | 6 | Set index of the displaced line |
| snp_valid | input | 1 | Snoop request present |
| snp_line | input | 27 | Line address of the snoop |
| snp_type | input | 3 | Operation type; bit 2 marks non-memory operations |
| snp_global | input | 1 | Snoop is marked global |
| resp_valid | output | 1 | Decision strobe, one cycle after the request |
| resp_fwd | output | 1 | 1: forward to the processor, 0: complete on the bus |

## Verification
The snoops are tried in three kinds of situation:
- Lines that are absent, present in the shadow directory, and present only in a copy-back register. This separates a directory hit from a castout hit from a true miss.
- Global and local memory types, plus the non-memory types. This shows that the global flag and the type decode each override the address compare in the right direction.
- Lines whose set matches but whose tag differs, allocations made without the global flag, a third displacement that overwrites the oldest castout, a write-with-kill followed by a read, and an allocation and a displacement to the same set in one cycle. These show that entries are written, overwritten and cleared at the right moment.

// File: rtl/sf_pkg.sv
package sf_pkg;

    typedef enum logic [1:0] {
        LS_I  = 2'b00,
        LS_S  = 2'b01,
        LS_EX = 2'b10
    } line_state_e;

    typedef enum logic [2:0] {
        OP_READ  = 3'b000,
        OP_RFO   = 3'b001,
        OP_WKILL = 3'b010,
        OP_KILL  = 3'b011,
        OP_TLBI  = 3'b100,
        OP_SYNC  = 3'b101,
        OP_MISC0 = 3'b110,
        OP_MISC1 = 3'b111
    } snoop_op_e;

    typedef enum logic [1:0] {
        RS_IDLE = 2'b00,
        RS_FWD  = 2'b01,
        RS_CMPL = 2'b10
    } resp_state_e;

    function automatic logic op_is_mem(input logic [2:0] op);
        return ~op[2];
    endfunction

endpackage

// File: rtl/sf_shadow_dir.sv
module sf_shadow_dir
    import sf_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [IDX_W-1:0] alloc_set,
    input  logic             alloc_shared,
    input  logic             alloc_global,
    input  logic             evict_valid,
    input  logic [IDX_W-1:0] evict_set,
    output logic [TAG_W-1:0] evict_tag,
    output logic             evict_vld,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [IDX_W-1:0] lk_set,
    output logic             dir_hit
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    line_state_e      st_q  [SETS];
    logic             vld_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= LS_I;
                vld_q[i] <= 1'b0;
            end
        end else begin
            if (evict_valid) begin
                st_q[evict_set]  <= LS_I;
                vld_q[evict_set] <= 1'b0;
            end
            if (alloc_valid) begin
                tag_q[alloc_set] <= alloc_tag;
                st_q[alloc_set]  <= alloc_shared ? LS_S : LS_EX;
                vld_q[alloc_set] <= alloc_global;
            end
        end
    end

    always_comb begin
        evict_tag = tag_q[evict_set];
        evict_vld = vld_q[evict_set];
        dir_hit   = vld_q[lk_set] && (st_q[lk_set] != LS_I)
                    && (tag_q[lk_set] == lk_tag);
    end

endmodule

// File: rtl/sf_castout_regs.sv
module sf_castout_regs #(
    parameter int LINE_W     = 27,
    parameter int CB_NUM     = 2,
    parameter bit KILL_CLEAR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] load_line,
    input  logic              load_vld,
    input  logic [LINE_W-1:0] lk_line,
    input  logic              kill_req,
    output logic              cb_hit
);
    localparam int PTR_W = (CB_NUM > 1) ? $clog2(CB_NUM) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [CB_NUM-1:0] match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= (ptr_q == PTR_W'(CB_NUM - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < CB_NUM; g++) begin : g_cb
        logic [LINE_W-1:0] line_q;
        logic              vld_q;

        assign match[g] = vld_q && (line_q == lk_line);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q <= '0;
                vld_q  <= 1'b0;
            end else if (load && (ptr_q == PTR_W'(g))) begin
                line_q <= load_line;
                vld_q  <= load_vld;
            end else if (KILL_CLEAR && kill_req && match[g]) begin
                vld_q  <= 1'b0;
            end
        end
    end

    assign cb_hit = |match;

endmodule

// File: rtl/sf_resp_fsm.sv
module sf_resp_fsm
    import sf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snp_valid,
    input  logic [2:0] snp_type,
    input  logic       snp_global,
    input  logic       dir_hit,
    input  logic       cb_hit,
    output logic       resp_valid,
    output logic       resp_fwd
);
    resp_state_e state_q, state_d;
    logic        must_fwd;

    always_comb begin
        must_fwd = !op_is_mem(snp_type)
                   || (snp_global && (dir_hit || cb_hit));
        if (!snp_valid) begin
            state_d = RS_IDLE;
        end else if (must_fwd) begin
            state_d = RS_FWD;
        end else begin
            state_d = RS_CMPL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        resp_valid = 1'b0;
        resp_fwd   = 1'b0;
        unique case (state_q)
            RS_IDLE: ;
            RS_FWD: begin
                resp_valid = 1'b1;
                resp_fwd   = 1'b1;
            end
            RS_CMPL: resp_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/snoop_filter_dir.sv
module snoop_filter_dir
    import sf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFFSET_W   = 5,
    parameter int IDX_W      = 6,
    parameter int CB_NUM     = 2,
    parameter bit KILL_CLEAR = 1'b1,
    localparam int LINE_W    = ADDR_W - OFFSET_W,
    localparam int TAG_W     = LINE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic              alloc_shared,
    input  logic              alloc_global,
    input  logic              evict_valid,
    input  logic [IDX_W-1:0]  evict_set,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    input  logic [2:0]        snp_type,
    input  logic              snp_global,
    output logic              resp_valid,
    output logic              resp_fwd
);
    logic             dir_hit;
    logic             cb_hit;
    logic [TAG_W-1:0] ev_tag;
    logic             ev_vld;
    logic             kill_req;

    assign kill_req = snp_valid && snp_global && (snp_type == OP_WKILL);

    sf_shadow_dir #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_dir (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid  (alloc_valid),
        .alloc_tag    (alloc_line[LINE_W-1:IDX_W]),
        .alloc_set    (alloc_line[IDX_W-1:0]),
        .alloc_shared (alloc_shared),
        .alloc_global (alloc_global),
        .evict_valid  (evict_valid),
        .evict_set    (evict_set),
        .evict_tag    (ev_tag),
        .evict_vld    (ev_vld),
        .lk_tag       (snp_line[LINE_W-1:IDX_W]),
        .lk_set       (snp_line[IDX_W-1:0]),
        .dir_hit      (dir_hit)
    );

    sf_castout_regs #(
        .LINE_W     (LINE_W),
        .CB_NUM     (CB_NUM),
        .KILL_CLEAR (KILL_CLEAR)
    ) u_cb (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (evict_valid),
        .load_line ({ev_tag, evict_set}),
        .load_vld  (ev_vld),
        .lk_line   (snp_line),
        .kill_req  (kill_req),
        .cb_hit    (cb_hit)
    );

    sf_resp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .snp_valid  (snp_valid),
        .snp_type   (snp_type),
        .snp_global (snp_global),
        .dir_hit    (dir_hit),
        .cb_hit     (cb_hit),
        .resp_valid (resp_valid),
        .resp_fwd   (resp_fwd)
    );

endmodule

// File: rtl/sf_checker.sv
module sf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       snp_valid,
    input logic [2:0] snp_type,
    input logic       snp_global,
    input logic       dir_hit,
    input logic       cb_hit,
    input logic       resp_valid,
    input logic       resp_fwd
);
    p_answer_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> resp_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !resp_valid);

    p_fwd_has_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fwd |-> resp_valid);

    p_nonmem_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_type[2]) |=> resp_fwd);

    p_local_cmpl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_type[2] && !snp_global) |=> !resp_fwd);

    p_hit_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_type[2] && snp_global && (dir_hit || cb_hit))
        |=> resp_fwd);

    p_miss_cmpl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_type[2] && snp_global && !dir_hit && !cb_hit)
        |=> !resp_fwd);
endmodule

bind snoop_filter_dir sf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_valid  (snp_valid),
    .snp_type   (snp_type),
    .snp_global (snp_global),
    .dir_hit    (dir_hit),
    .cb_hit     (cb_hit),
    .resp_valid (resp_valid),
    .resp_fwd   (resp_fwd)
);

// File: tb/snoop_filter_dir_tb.sv
module snoop_filter_dir_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 27;
    localparam int IDX_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [LINE_W-1:0] alloc_line = '0;
    logic              alloc_shared = 1'b0;
    logic              alloc_global = 1'b0;
    logic              evict_valid = 1'b0;
    logic [IDX_W-1:0]  evict_set = '0;
    logic              snp_valid = 1'b0;
    logic [LINE_W-1:0] snp_line = '0;
    logic [2:0]        snp_type = '0;
    logic              snp_global = 1'b0;
    logic              resp_valid;
    logic              resp_fwd;

    int n_checks = 0;
    int n_fails  = 0;
    int n_reqs   = 0;
    int n_resps  = 0;
    bit exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_filter_dir u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid  (alloc_valid),
        .alloc_line   (alloc_line),
        .alloc_shared (alloc_shared),
        .alloc_global (alloc_global),
        .evict_valid  (evict_valid),
        .evict_set    (evict_set),
        .snp_valid    (snp_valid),
        .snp_line     (snp_line),
        .snp_type     (snp_type),
        .snp_global   (snp_global),
        .resp_valid   (resp_valid),
        .resp_fwd     (resp_fwd)
    );

    function automatic logic [LINE_W-1:0] ln(input int tag, input int set);
        return {21'(tag), 6'(set)};
    endfunction

    // monitor: pops one expected decision per strobe
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            n_resps++;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R2: strobe with no request, actual fwd=%0b expected none", resp_fwd);
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (resp_fwd !== e) begin
                    n_fails++;
                    $display("FAIL %s: resp_fwd actual=%0b expected=%0b", t, resp_fwd, e);
                end
            end
        end
    end

    task automatic snoop(input logic [LINE_W-1:0] l, input logic [2:0] ty,
                         input logic g, input bit e, input string t);
        snp_valid  = 1'b1;
        snp_line   = l;
        snp_type   = ty;
        snp_global = g;
        exp_q.push_back(e);
        tag_q.push_back(t);
        n_reqs++;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic alloc(input logic [LINE_W-1:0] l, input logic sh, input logic g);
        alloc_valid  = 1'b1;
        alloc_line   = l;
        alloc_shared = sh;
        alloc_global = g;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic evict(input int set);
        evict_valid = 1'b1;
        evict_set   = 6'(set);
        @(negedge clk);
        evict_valid = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (resp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: resp_valid actual=%0b expected=0", resp_valid);
        end
        snoop(ln(5, 3), 3'b000, 1'b1, 1'b0, "R1");
        snoop(ln(0, 0), 3'b001, 1'b1, 1'b0, "R1");

        alloc(ln(5, 3), 1'b0, 1'b1);
        snoop(ln(5, 3), 3'b000, 1'b1, 1'b1, "R5");
        snoop(ln(5, 3), 3'b001, 1'b0, 1'b0, "R4");
        snoop(ln(6, 3), 3'b000, 1'b1, 1'b0, "R11");
        snoop(ln(77, 40), 3'b100, 1'b0, 1'b1, "R3");
        snoop(ln(5, 3), 3'b101, 1'b1, 1'b1, "R3");
        snoop(ln(1, 1), 3'b111, 1'b1, 1'b1, "R3");
        @(negedge clk);

        alloc(ln(9, 10), 1'b1, 1'b1);
        snoop(ln(9, 10), 3'b001, 1'b1, 1'b1, "R7");
        alloc(ln(11, 12), 1'b0, 1'b0);
        snoop(ln(11, 12), 3'b000, 1'b1, 1'b0, "R6");

        evict(3);
        snoop(ln(5, 3), 3'b000, 1'b1, 1'b1, "R8");
        evict(12);
        snoop(ln(11, 12), 3'b000, 1'b1, 1'b0, "R8");
        evict(10);
        snoop(ln(5, 3), 3'b000, 1'b1, 1'b0, "R9");
        snoop(ln(9, 10), 3'b000, 1'b1, 1'b1, "R9");

        snoop(ln(9, 10), 3'b010, 1'b1, 1'b1, "R10");
        snoop(ln(9, 10), 3'b000, 1'b1, 1'b0, "R10");

        alloc(ln(7, 20), 1'b0, 1'b1);
        alloc_valid  = 1'b1;
        alloc_line   = ln(8, 20);
        alloc_shared = 1'b1;
        alloc_global = 1'b1;
        evict_valid  = 1'b1;
        evict_set    = 6'd20;
        @(negedge clk);
        alloc_valid = 1'b0;
        evict_valid = 1'b0;
        snoop(ln(8, 20), 3'b000, 1'b1, 1'b1, "R12");
        snoop(ln(7, 20), 3'b011, 1'b1, 1'b1, "R12");

        repeat (3) @(negedge clk);
        n_checks++;
        if (n_resps != n_reqs || exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R2: strobes actual=%0d expected=%0d", n_resps, n_reqs);
        end
        summary();
    end

endmodule